// File: doc/BRIEF.md
# Snooping MOESI Cache-Line Coherence Controller

This block holds the coherence state of every cached line for a small group of cores that share one snooping bus. Each core has its own controller with a state table indexed by line address. The controller takes load, store and evict requests from its processor. It decides whether a request can finish locally or needs a bus transaction. It also updates its own lines when it sees another core's transactions on the bus. A round-robin arbiter lets one core drive the bus at a time. The block keeps only state and control: no data is stored, and memory appears only as a read strobe and a write strobe.

The protocol has five states: Invalid, Shared, Exclusive, Owned and Modified. A dirty line that is read by another core moves to Owned. It keeps feeding later readers directly, and memory is not updated until that line is evicted. A write to a line that is already present in Shared or Owned uses a cheap upgrade command that moves no data. A write from Invalid uses a read-for-ownership command, which fetches the line and invalidates every other copy in the same transaction.

Processor requests use a valid/ready handshake. A core raises `req_valid` together with `req_op` and `req_addr`, and must hold all three steady until it sees `req_ready` high at a rising clock edge. The request completes at that edge. `req_ready` rises in the cycle the request finishes:
- A request that needs no bus finishes in the cycle it is presented.
- A request that needs the bus finishes in the cycle its bus grant arrives.

A core that is not granted is back-pressured for as long as other cores hold the bus.

Top module: `coh_snoop_top`

## Requirements
- R1: A load (req_op 0) to a line in Invalid issues a read (bus_cmd 0). If no other core holds the line (bus_shared low), the line becomes Exclusive (cur_state 2).
- R2: A load to an Invalid line that another core holds issues a read with bus_shared high and installs the line as Shared (cur_state 1). A read never invalidates any other copy.
- R3: A store (req_op 1) to an Invalid line issues a read-for-ownership (bus_cmd 1) and leaves the line Modified (cur_state 4). Every other copy becomes Invalid (cur_state 0). A Modified or Owned holder supplies the data (bus_supplied high, mem_read low); otherwise memory supplies it (mem_read high).
- R4: A store to a Shared or Owned line issues an upgrade (bus_cmd 2) with bus_supplied and mem_read both low. The writer becomes Modified and all other copies become Invalid.
- R5: A store to an Exclusive or Modified line causes no bus transaction, and the line becomes Modified.
- R6: A Modified line that snoops a read supplies the data and becomes Owned (cur_state 3), with mem_write low. An Owned line that snoops a read supplies the data and stays Owned. An Exclusive line that snoops a read becomes Shared and does not supply.
- R7: Evicting (req_op 2) a Modified or Owned line issues a write-back (bus_cmd 3, mem_write high) and leaves the line Invalid. Evicting a clean line makes it Invalid with no bus transaction.
- R8: When every core reads the same line, all copies end Shared and no read-for-ownership or upgrade appears on the bus.
- R9: At most one core is granted per cycle, and the grant rotates round-robin starting after the last granted core. `bus_owner` names the granted core. A core that needs the bus keeps req_ready low until its grant cycle, and req_ready is high in that cycle.
- R10: After reset every line of every core is Invalid, and bus_valid, mem_read and mem_write are low while no core requests.
- R11: cur_state shows, for each core, the state of the line at that core's req_addr. It does this whether or not req_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORE | Per-core request valid |
| req_op | input | 2*NCORE | Per-core operation: 0 load, 1 store, 2 evict, 3 no-op |
| req_addr | input | AW*NCORE | Per-core line address |
| req_ready | output | NCORE | Per-core request completes this cycle |
| cur_state | output | 3*NCORE | Per-core state of the line at req_addr: 0 I, 1 S, 2 E, 3 O, 4 M |
| bus_valid | output | 1 | A bus transaction occupies this cycle |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_addr | output | AW | Line address of the transaction |
| bus_owner | output | $clog2(NCORE) | Index of the granted core |
| bus_shared | output | 1 | Some other core holds the line |
| bus_supplied | output | 1 | A dirty holder supplies the data instead of memory |
| mem_read | output | 1 | Memory supplies the line data |
| mem_write | output | 1 | Memory accepts a write-back |

## Verification
The bus outputs and `req_ready` are combinational. They are due in the same cycle a request is presented or granted. The bench drives each request just after a falling edge, reads `req_ready` 1 ns later and the bus fields 3 ns later, so all values are taken while the inputs are stable. A line state change is due at the rising edge that completes the transaction. The bench reads `cur_state` in the low phase that follows. An expected-transaction queue is filled before each request. A bus cycle that arrives with the queue empty is reported, and this is how the silent store and clean-evict paths are checked.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NOP   = 2'd3
  } cpu_op_t;

  typedef enum logic [1:0] {
    CMD_RD   = 2'd0,
    CMD_RDX  = 2'd1,
    CMD_UPGR = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_t;

  function automatic logic is_dirty(line_st_t s);
    return (s == ST_M) || (s == ST_O);
  endfunction

  function automatic logic carries_data(bus_cmd_t c);
    return (c == CMD_RD) || (c == CMD_RDX);
  endfunction
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int N   = 4,
  parameter int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  output logic [N-1:0]   gnt,
  output logic [IDW-1:0] gnt_idx
);
  logic [IDW-1:0] last_q;
  logic           found;
  int             idx;

  // search starts one past the last winner, wraps around
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    idx     = 0;
    for (int off = 1; off <= N; off++) begin
      idx = (int'(last_q) + off) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        gnt_idx  = IDW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= IDW'(N - 1);
    else if (|req)   last_q <= gnt_idx;
  end
endmodule

// File: rtl/coh_core_ctrl.sv
module coh_core_ctrl
  import coh_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic [2:0]    cur_state,
  output logic          bus_req,
  output logic [1:0]    req_cmd,
  input  logic          grant,
  input  logic          bus_valid,
  input  logic [1:0]    bus_cmd,
  input  logic [AW-1:0] bus_addr,
  input  logic          shared_in,
  output logic          snoop_hit,
  output logic          snoop_supply
);
  localparam int NL = 1 << AW;

  line_st_t st_q [NL];
  line_st_t cur, snp, local_st, fill_st, snoop_st;
  bus_cmd_t cmd, seen;
  logic     need, conflict;

  assign cur  = st_q[req_addr];
  assign snp  = st_q[bus_addr];
  assign seen = bus_cmd_t'(bus_cmd);

  // what the request needs: bus command, or a purely local change
  always_comb begin
    need     = 1'b0;
    cmd      = CMD_RD;
    local_st = cur;
    case (cpu_op_t'(req_op))
      OP_LOAD: begin
        if (cur == ST_I) begin
          need = 1'b1;
          cmd  = CMD_RD;
        end
      end
      OP_STORE: begin
        case (cur)
          ST_I:       begin need = 1'b1; cmd = CMD_RDX;  end
          ST_S, ST_O: begin need = 1'b1; cmd = CMD_UPGR; end
          default:    local_st = ST_M;
        endcase
      end
      OP_EVICT: begin
        if (is_dirty(cur)) begin
          need = 1'b1;
          cmd  = CMD_WB;
        end else begin
          local_st = ST_I;
        end
      end
      default: local_st = cur;
    endcase
  end

  // state taken by the requester once its transaction runs
  always_comb begin
    case (cmd)
      CMD_RD:  fill_st = shared_in ? ST_S : ST_E;
      CMD_WB:  fill_st = ST_I;
      default: fill_st = ST_M;
    endcase
  end

  // reaction to another core's transaction
  always_comb begin
    snoop_st = snp;
    case (seen)
      CMD_RD: begin
        if (snp == ST_M)      snoop_st = ST_O;
        else if (snp == ST_E) snoop_st = ST_S;
      end
      CMD_RDX, CMD_UPGR: snoop_st = ST_I;
      default: snoop_st = snp;
    endcase
  end

  // a local-only change waits while a snoop hits the same line
  assign conflict     = bus_valid && !grant && (bus_addr == req_addr);
  assign bus_req      = req_valid && need;
  assign req_ready    = req_valid && (need ? grant : !conflict);
  assign req_cmd      = cmd;
  assign cur_state    = cur;
  assign snoop_hit    = (snp != ST_I);
  assign snoop_supply = is_dirty(snp) && carries_data(seen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) st_q[i] <= ST_I;
    end else if (grant) begin
      st_q[req_addr] <= fill_st;
    end else begin
      if (req_valid && !need && !conflict) st_q[req_addr] <= local_st;
      if (bus_valid)                       st_q[bus_addr] <= snoop_st;
    end
  end
endmodule

// File: rtl/coh_bus_join.sv
module coh_bus_join
  import coh_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 3
) (
  input  logic [N-1:0]    gnt,
  input  logic [2*N-1:0]  cmd_vec,
  input  logic [AW*N-1:0] addr_vec,
  input  logic [N-1:0]    hit_vec,
  input  logic [N-1:0]    supply_vec,
  output logic            bus_valid,
  output logic [1:0]      bus_cmd,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_shared,
  output logic            bus_supplied,
  output logic            mem_read,
  output logic            mem_write
);
  logic [N-1:0] others;

  assign bus_valid = |gnt;
  assign others    = ~gnt;

  // AND-OR mux of the granted core's command and address
  always_comb begin
    bus_cmd  = '0;
    bus_addr = '0;
    for (int i = 0; i < N; i++) begin
      bus_cmd  = bus_cmd  | ({2{gnt[i]}}  & cmd_vec[2*i +: 2]);
      bus_addr = bus_addr | ({AW{gnt[i]}} & addr_vec[AW*i +: AW]);
    end
  end

  // wired-OR responses from every core except the requester
  assign bus_shared   = bus_valid && |(hit_vec & others);
  assign bus_supplied = bus_valid && |(supply_vec & others);
  assign mem_read     = bus_valid && carries_data(bus_cmd_t'(bus_cmd)) && !bus_supplied;
  assign mem_write    = bus_valid && (bus_cmd_t'(bus_cmd) == CMD_WB);
endmodule

// File: rtl/coh_snoop_top.sv
module coh_snoop_top #(
  parameter int NCORE = 4,
  parameter int AW    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCORE-1:0]           req_valid,
  input  logic [2*NCORE-1:0]         req_op,
  input  logic [AW*NCORE-1:0]        req_addr,
  output logic [NCORE-1:0]           req_ready,
  output logic [3*NCORE-1:0]         cur_state,
  output logic                       bus_valid,
  output logic [1:0]                 bus_cmd,
  output logic [AW-1:0]              bus_addr,
  output logic [$clog2(NCORE)-1:0]   bus_owner,
  output logic                       bus_shared,
  output logic                       bus_supplied,
  output logic                       mem_read,
  output logic                       mem_write
);
  localparam int IDW = $clog2(NCORE);

  logic [NCORE-1:0]   bus_req_vec, gnt_vec, hit_vec, supply_vec;
  logic [2*NCORE-1:0] cmd_vec;

  coh_rr_arb #(.N(NCORE), .IDW(IDW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (bus_req_vec),
    .gnt     (gnt_vec),
    .gnt_idx (bus_owner)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    coh_core_ctrl #(.AW(AW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid[c]),
      .req_op       (req_op[2*c +: 2]),
      .req_addr     (req_addr[AW*c +: AW]),
      .req_ready    (req_ready[c]),
      .cur_state    (cur_state[3*c +: 3]),
      .bus_req      (bus_req_vec[c]),
      .req_cmd      (cmd_vec[2*c +: 2]),
      .grant        (gnt_vec[c]),
      .bus_valid    (bus_valid),
      .bus_cmd      (bus_cmd),
      .bus_addr     (bus_addr),
      .shared_in    (bus_shared),
      .snoop_hit    (hit_vec[c]),
      .snoop_supply (supply_vec[c])
    );
  end

  coh_bus_join #(.N(NCORE), .AW(AW)) u_join (
    .gnt          (gnt_vec),
    .cmd_vec      (cmd_vec),
    .addr_vec     (req_addr),
    .hit_vec      (hit_vec),
    .supply_vec   (supply_vec),
    .bus_valid    (bus_valid),
    .bus_cmd      (bus_cmd),
    .bus_addr     (bus_addr),
    .bus_shared   (bus_shared),
    .bus_supplied (bus_supplied),
    .mem_read     (mem_read),
    .mem_write    (mem_write)
  );
endmodule

// File: rtl/coh_snoop_chk.sv
module coh_snoop_chk #(
  parameter int NCORE = 4,
  parameter int IDW   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCORE-1:0]   gnt_vec,
  input logic [NCORE-1:0]   req_ready,
  input logic [3*NCORE-1:0] cur_state,
  input logic               bus_valid,
  input logic [1:0]         bus_cmd,
  input logic [IDW-1:0]     bus_owner,
  input logic               bus_supplied,
  input logic               mem_read,
  input logic               mem_write
);
  logic [2:0] own_st;
  logic       own_ready;

  always_comb begin
    own_st    = '0;
    own_ready = 1'b0;
    for (int c = 0; c < NCORE; c++) begin
      if (int'(bus_owner) == c) begin
        own_st    = cur_state[3*c +: 3];
        own_ready = req_ready[c];
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec)); // R9
  AST_READY_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> own_ready && gnt_vec[bus_owner]); // R9
  AST_RD_FROM_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_cmd == 2'd0 |-> own_st == 3'd0); // R1
  AST_UPGR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_cmd == 2'd2 |-> (own_st == 3'd1 || own_st == 3'd3) && !bus_supplied && !mem_read); // R4
  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_cmd == 2'd3 |-> own_st == 3'd3 || own_st == 3'd4); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !mem_read && !mem_write && !bus_supplied); // R10
endmodule

bind coh_snoop_top coh_snoop_chk #(.NCORE(NCORE), .IDW(IDW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .gnt_vec      (gnt_vec),
  .req_ready    (req_ready),
  .cur_state    (cur_state),
  .bus_valid    (bus_valid),
  .bus_cmd      (bus_cmd),
  .bus_owner    (bus_owner),
  .bus_supplied (bus_supplied),
  .mem_read     (mem_read),
  .mem_write    (mem_write)
);

// File: tb/sim_coh_snoop_top.sv
module sim_coh_snoop_top;
  localparam int N  = 4;
  localparam int AW = 3;
  localparam int LD = 0, STR = 1, EV = 2;
  localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;
  localparam int RD = 0, RDX = 1, UPG = 2, WB = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [N-1:0]    req_ready;
  logic [3*N-1:0]  cur_state;
  logic            bus_valid, bus_shared, bus_supplied, mem_read, mem_write;
  logic [1:0]      bus_cmd;
  logic [AW-1:0]   bus_addr;
  logic [1:0]      bus_owner;

  int checks = 0;
  int errors = 0;
  int inv_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    int    cmd;
    int    addr;
    int    owner;
    int    sh;
    int    sup;
    string tag;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  coh_snoop_top #(.NCORE(N), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_ready(req_ready), .cur_state(cur_state),
    .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_owner(bus_owner), .bus_shared(bus_shared), .bus_supplied(bus_supplied),
    .mem_read(mem_read), .mem_write(mem_write)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_bus(input int cmd, input int addr, input int owner,
                            input int sh, input int sup, input string tag);
    exp_t e;
    e.cmd = cmd; e.addr = addr; e.owner = owner; e.sh = sh; e.sup = sup; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic run_op(input int c, input int op, input int addr);
    @(negedge clk);
    req_op[2*c +: 2]    = 2'(op);
    req_addr[AW*c +: AW] = AW'(addr);
    req_valid[c]        = 1'b1;
    #1;
    while (!req_ready[c]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid[c] = 1'b0;
  endtask

  task automatic chk_state(input int c, input int addr, input int exp, input string tag);
    @(negedge clk);
    req_addr[AW*c +: AW] = AW'(addr);
    #1;
    chk(tag, int'(cur_state[3*c +: 3]), exp);
  endtask

  // monitor: pops the scoreboard on every bus cycle
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && bus_valid) begin
        if (bus_cmd == 2'd1 || bus_cmd == 2'd2) inv_cnt++;
        if (expq.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R5/R7 unexpected bus transaction cmd=%0d addr=%0d owner=%0d actual=1 expected=0",
                   bus_cmd, bus_addr, bus_owner);
        end else begin
          it = expq.pop_front();
          chk({it.tag, " cmd"}, int'(bus_cmd), it.cmd);
          chk({it.tag, " addr"}, int'(bus_addr), it.addr);
          chk({it.tag, " owner"}, int'(bus_owner), it.owner);
          chk({it.tag, " shared"}, int'(bus_shared), it.sh);
          chk({it.tag, " supplied"}, int'(bus_supplied), it.sup);
          chk({it.tag, " mem_read"}, int'(mem_read),
              ((it.cmd == RD || it.cmd == RDX) && it.sup == 0) ? 1 : 0);
          chk({it.tag, " mem_write"}, int'(mem_write), (it.cmd == WB) ? 1 : 0);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    int inv0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state
    for (int c = 0; c < N; c++) chk_state(c, 1, SI, "R10 reset state");
    chk("R10 idle bus_valid", int'(bus_valid), 0);
    chk("R10 idle mem_write", int'(mem_write), 0);

    // R1 then R5: cold load alone, then silent store
    expect_bus(RD, 1, 0, 0, 0, "R1 c0 load a1");
    run_op(0, LD, 1);
    chk_state(0, 1, SE, "R1 c0 a1 exclusive");
    run_op(0, STR, 1);
    chk_state(0, 1, SM, "R5 c0 silent store to M");

    // R6/R2: M snoops a read -> O, requester S
    expect_bus(RD, 1, 1, 1, 1, "R6 c1 load a1 from M");
    run_op(1, LD, 1);
    chk_state(1, 1, SS, "R2 c1 a1 shared");
    chk_state(0, 1, SO, "R6 c0 a1 owned");
    expect_bus(RD, 1, 2, 1, 1, "R6 c2 load a1 from O");
    run_op(2, LD, 1);
    chk_state(0, 1, SO, "R6 c0 stays owned");
    chk_state(2, 1, SS, "R2 c2 a1 shared");

    // R4: upgrade from S
    expect_bus(UPG, 1, 1, 1, 0, "R4 c1 store a1 from S");
    run_op(1, STR, 1);
    chk_state(1, 1, SM, "R4 c1 a1 modified");
    chk_state(0, 1, SI, "R4 c0 a1 invalidated");
    chk_state(2, 1, SI, "R4 c2 a1 invalidated");

    // R3: store from I with a dirty holder
    expect_bus(RDX, 1, 3, 1, 1, "R3 c3 store a1 from I");
    run_op(3, STR, 1);
    chk_state(3, 1, SM, "R3 c3 a1 modified");
    chk_state(1, 1, SI, "R3 c1 a1 invalidated");

    // R7: dirty evict writes back
    expect_bus(WB, 1, 3, 0, 0, "R7 c3 evict a1");
    run_op(3, EV, 1);
    chk_state(3, 1, SI, "R7 c3 a1 invalid after WB");

    // R7: clean evict silent
    expect_bus(RD, 2, 0, 0, 0, "R1 c0 load a2");
    run_op(0, LD, 2);
    run_op(0, EV, 2);
    chk_state(0, 2, SI, "R7 c0 clean evict silent");

    // R3: store from I, nobody holds -> memory supplies
    expect_bus(RDX, 3, 2, 0, 0, "R3 c2 store a3 cold");
    run_op(2, STR, 3);
    chk_state(2, 3, SM, "R3 c2 a3 modified");

    // R8: all cores read a4
    inv0 = inv_cnt;
    expect_bus(RD, 4, 0, 0, 0, "R8 c0 load a4");
    expect_bus(RD, 4, 1, 1, 0, "R8 c1 load a4 (E no supply)");
    expect_bus(RD, 4, 2, 1, 0, "R8 c2 load a4");
    expect_bus(RD, 4, 3, 1, 0, "R8 c3 load a4");
    for (int c = 0; c < N; c++) run_op(c, LD, 4);
    for (int c = 0; c < N; c++) chk_state(c, 4, SS, "R8 all shared");
    chk("R8 no invalidating txns", inv_cnt - inv0, 0);

    // R4/R7 on an Owned line
    expect_bus(RDX, 5, 0, 0, 0, "R3 c0 store a5");
    run_op(0, STR, 5);
    expect_bus(RD, 5, 1, 1, 1, "R6 c1 load a5");
    run_op(1, LD, 5);
    expect_bus(UPG, 5, 0, 1, 0, "R4 c0 store a5 from O");
    run_op(0, STR, 5);
    chk_state(0, 5, SM, "R4 c0 O to M");
    chk_state(1, 5, SI, "R4 c1 a5 invalidated");
    chk_state(0, 5, SM, "R11 cur_state with valid low");
    expect_bus(RD, 5, 1, 1, 1, "R6 c1 reload a5");
    run_op(1, LD, 5);
    expect_bus(WB, 5, 0, 1, 0, "R7 c0 evict owned a5");
    run_op(0, EV, 5);
    chk_state(0, 5, SI, "R7 c0 a5 invalid");
    chk_state(1, 5, SS, "R7 c1 a5 keeps shared");

    // R9: two simultaneous requests, last winner was c0 -> c1 then c2
    expect_bus(RD, 6, 1, 0, 0, "R9 c1 first grant");
    expect_bus(RD, 6, 2, 1, 0, "R9 c2 second grant");
    fork
      run_op(1, LD, 6);
      run_op(2, LD, 6);
      begin
        @(negedge clk);
        #2;
        chk("R9 c2 stalled", int'(req_ready[2]), 0);
        chk("R9 c1 granted", int'(req_ready[1]), 1);
      end
    join
    chk_state(1, 6, SS, "R9 c1 a6 shared");
    chk_state(2, 6, SS, "R9 c2 a6 shared");

    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", expq.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule